// File: doc/BRIEF.md
# Repeated-Addition Sequential Multiplier

This block multiplies two unsigned 4-bit operands by summing the multiplicand into an 8-bit accumulator once for each unit of the multiplier. When a start pulse is accepted, the multiplicand is captured in a holding register and the multiplier goes into a loadable down counter. The accumulator and an iteration counter are cleared at the same time. The controller then adds one copy of the multiplicand per clock, counts the multiplier down and the iteration counter up, and stops when the down counter is empty.

Latency depends on the data: a multiplier of value B costs B addition cycles plus one setup cycle. A one-cycle done pulse marks completion. After that the product and the iteration count stay on the outputs until a new start is accepted. The external reset is asserted asynchronously and released through a two-stage synchronizer.

Top module: `rep_add_mult`

## Requirements
- R1: While reset is asserted, and after it is released, `done_o` is 0, `product_o` is 0 and `iter_o` is 0 until the first start is accepted.
- R2: `start_i` is accepted only while the block is idle. Both operands are sampled on the accepting clock edge. Later changes of the operands, and start pulses before completion, do not change the result or its timing.
- R3: In the cycle after the accepting edge, `product_o` and `iter_o` read 0.
- R4: At completion `product_o` equals the unsigned product `mcand_i` × `mplier_i`. It is 8 bits wide and 15×15 = 225 is the largest value.
- R5: If start is accepted at edge n, `done_o` is high in the cycle after edge n+B+1, where B is the sampled multiplier. It is low in every cycle between the accepting edge and that edge.
- R6: A multiplier of 0 skips the addition phase. `done_o` rises after edge n+1 with `product_o` = 0.
- R7: `done_o` stays high for exactly one cycle.
- R8: After completion, `product_o` and `iter_o` hold their values until the next accepted start.
- R9: At completion `iter_o` equals the sampled multiplier B.
- R10: During the addition phase, each clock raises `product_o` by the multiplicand and `iter_o` by one. After edge n+1+j, `product_o` = A·j.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Request to begin a multiplication (accepted when idle) |
| mcand_i | input | 4 | Multiplicand A |
| mplier_i | input | 4 | Multiplier B, loaded into the down counter |
| done_o | output | 1 | One-cycle completion pulse |
| product_o | output | 8 | Accumulator D; holds the final product after completion |
| iter_o | output | 4 | Iteration counter C |

## Verification
A controller state that is wrong shows up as a done pulse in the wrong cycle. A stuck or repeated state shows up as a pulse wider than one cycle. Both are visible within B+2 cycles of the start. A down counter that is corrupted or loaded one step off changes both the completion cycle and the final `iter_o`. The accumulator is visible on every cycle through `product_o`, so a dropped or doubled addition appears on the very next clock as a step that is not equal to A. A start that is wrongly accepted while busy clears the accumulator, and the following cycle shows it as a 0 where the bench expects a partial sum.

// File: rtl/rpm_pkg.sv
package rpm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_ADD  = 2'd2,
    ST_DONE = 2'd3
  } rpm_state_e;
endpackage

// File: rtl/rpm_rst_sync.sv
module rpm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/rpm_ctrl.sv
module rpm_ctrl
  import rpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       cnt_zero_i,
  input  logic       cnt_one_i,
  output rpm_state_e state_o,
  output logic       load_o,
  output logic       add_o,
  output logic       done_o
);
  rpm_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_LOAD;
      ST_LOAD: state_d = cnt_zero_i ? ST_DONE : ST_ADD;
      ST_ADD:  if (cnt_one_i) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign load_o  = (state_q == ST_IDLE) && start_i;
  assign add_o   = (state_q == ST_ADD);
  assign done_o  = (state_q == ST_DONE);
  assign state_o = state_q;
endmodule

// File: rtl/rpm_down_cnt.sv
module rpm_down_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o,
  output logic         zero_o,
  output logic         one_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign cnt_en = load_i | dec_i;

  always_comb begin
    if (load_i) cnt_d = load_val_i;
    else        cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);
  assign one_o  = (cnt_q == W'(1));
endmodule

// File: rtl/rpm_up_cnt.sv
module rpm_up_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign cnt_en = clr_i | inc_i;

  always_comb begin
    if (clr_i) cnt_d = '0;
    else       cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/rpm_accum.sv
module rpm_accum #(
  parameter int OP_W  = 4,
  parameter int ACC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             add_i,
  input  logic [OP_W-1:0]  opnd_i,
  output logic [OP_W-1:0]  opnd_o,
  output logic [ACC_W-1:0] acc_o
);
  localparam int PAD_W = ACC_W - OP_W;

  logic [OP_W-1:0]  opnd_q;
  logic [ACC_W-1:0] acc_q, acc_d;
  logic             acc_en;

  assign acc_en = load_i | add_i;

  always_comb begin
    if (load_i) acc_d = '0;
    else        acc_d = acc_q + {{PAD_W{1'b0}}, opnd_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      opnd_q <= '0;
    else if (load_i) opnd_q <= opnd_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  assign opnd_o = opnd_q;
  assign acc_o  = acc_q;
endmodule

// File: rtl/rep_add_mult.sv
module rep_add_mult
  import rpm_pkg::*;
#(
  parameter int OP_W = 4,
  localparam int PROD_W = 2 * OP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [OP_W-1:0]   mcand_i,
  input  logic [OP_W-1:0]   mplier_i,
  output logic              done_o,
  output logic [PROD_W-1:0] product_o,
  output logic [OP_W-1:0]   iter_o
);
  logic       rst_sync_n;
  rpm_state_e state;
  logic       load, add, cnt_zero, cnt_one;
  logic [OP_W-1:0] mcand_q, mplier_cnt;

  rpm_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rpm_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start_i    (start_i),
    .cnt_zero_i (cnt_zero),
    .cnt_one_i  (cnt_one),
    .state_o    (state),
    .load_o     (load),
    .add_o      (add),
    .done_o     (done_o)
  );

  rpm_down_cnt #(.W(OP_W)) u_mplier_cnt (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load_i     (load),
    .load_val_i (mplier_i),
    .dec_i      (add),
    .cnt_o      (mplier_cnt),
    .zero_o     (cnt_zero),
    .one_o      (cnt_one)
  );

  rpm_up_cnt #(.W(OP_W)) u_iter_cnt (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr_i (load),
    .inc_i (add),
    .cnt_o (iter_o)
  );

  rpm_accum #(.OP_W(OP_W), .ACC_W(PROD_W)) u_accum (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .load_i (load),
    .add_i  (add),
    .opnd_i (mcand_i),
    .opnd_o (mcand_q),
    .acc_o  (product_o)
  );
endmodule

// File: rtl/rpm_chk.sv
module rpm_chk
  import rpm_pkg::*;
#(
  parameter int OP_W = 4,
  localparam int PROD_W = 2 * OP_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input rpm_state_e        state,
  input logic [OP_W-1:0]   mcand_q,
  input logic [OP_W-1:0]   mplier_cnt,
  input logic              done_o,
  input logic [PROD_W-1:0] product_o,
  input logic [OP_W-1:0]   iter_o
);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R3
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && start_i) |=> (product_o == '0 && iter_o == '0 && !done_o));

  // R6
  zero_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOAD && mplier_cnt == '0) |=> (done_o && product_o == '0));

  // R10
  add_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ADD) |=> (product_o == $past(product_o) + {{(PROD_W-OP_W){1'b0}}, mcand_q}
                           && iter_o == $past(iter_o) + OP_W'(1)));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || (state == ST_IDLE && !start_i)) |=> ($stable(product_o) && $stable(iter_o)));
endmodule

bind rep_add_mult rpm_chk #(.OP_W(OP_W)) u_rpm_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .start_i    (start_i),
  .state      (state),
  .mcand_q    (mcand_q),
  .mplier_cnt (mplier_cnt),
  .done_o     (done_o),
  .product_o  (product_o),
  .iter_o     (iter_o)
);

// File: tb/rep_add_mult_tb_top.sv
module rep_add_mult_tb_top;
  localparam int NVEC = 10;
  // each entry: {multiplicand, multiplier, expected product}
  localparam logic [15:0] VEC [NVEC] = '{
    {4'd3,  4'd5,  8'd15},
    {4'd15, 4'd15, 8'd225},
    {4'd0,  4'd7,  8'd0},
    {4'd7,  4'd0,  8'd0},
    {4'd1,  4'd1,  8'd1},
    {4'd15, 4'd1,  8'd15},
    {4'd1,  4'd15, 8'd15},
    {4'd9,  4'd12, 8'd108},
    {4'd6,  4'd6,  8'd36},
    {4'd11, 4'd2,  8'd22}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [3:0] mcand_i = '0;
  logic [3:0] mplier_i = '0;
  logic       done_o;
  logic [7:0] product_o;
  logic [3:0] iter_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  rep_add_mult dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .mcand_i   (mcand_i),
    .mplier_i  (mplier_i),
    .done_o    (done_o),
    .product_o (product_o),
    .iter_o    (iter_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // one multiplication; busy_poke drives a start with other operands while busy
  task automatic run_mult(input logic [3:0] a, input logic [3:0] b,
                          input logic [7:0] exp, input bit busy_poke);
    @(negedge clk);
    start_i  = 1'b1;
    mcand_i  = a;
    mplier_i = b;
    tick();                          // accepting edge n
    start_i  = 1'b0;
    mcand_i  = ~a;                   // R2: later operand changes ignored
    mplier_i = ~b;
    chk("R3 product cleared", product_o, 0);
    chk("R3 iter cleared", iter_o, 0);
    chk("R5 done low after accept", done_o, 0);
    for (int i = 1; i <= int'(b); i++) begin
      if (busy_poke && i == 1) start_i = 1'b1;
      tick();                        // edge n+i
      start_i = 1'b0;
      chk("R10 partial product", product_o, int'(a) * (i - 1));
      chk("R10 partial iter", iter_o, i - 1);
      chk("R5 done low while busy", done_o, 0);
    end
    tick();                          // edge n+B+1
    chk("R5 done timing", done_o, 1);
    chk("R4 product", product_o, int'(exp));
    chk("R9 iter equals multiplier", iter_o, int'(b));
    if (b == 0) chk("R6 zero multiplier product", product_o, 0);
    tick();
    chk("R7 done one cycle", done_o, 0);
    chk("R8 product held", product_o, int'(exp));
    tick();
    chk("R8 product held idle", product_o, int'(exp));
    chk("R8 iter held idle", iter_o, int'(b));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 done in reset", done_o, 0);
    chk("R1 product in reset", product_o, 0);
    chk("R1 iter in reset", iter_o, 0);
    rst_n = 1'b1;
    repeat (4) tick();
    chk("R1 done after reset", done_o, 0);
    chk("R1 product after reset", product_o, 0);

    for (int v = 0; v < NVEC; v++)
      run_mult(VEC[v][15:12], VEC[v][11:8], VEC[v][7:0], 1'b0);

    // R2: start pulses while busy must not restart the run
    run_mult(4'd13, 4'd9, 8'd117, 1'b1);
    run_mult(4'd5, 4'd3, 8'd15, 1'b1);
    run_mult(4'd4, 4'd0, 8'd0, 1'b1);

    // R6: multiplier zero right after a large product
    run_mult(4'd15, 4'd15, 8'd225, 1'b0);
    run_mult(4'd8, 4'd0, 8'd0, 1'b0);

    // R1: asynchronous reset clears a held result
    run_mult(4'd10, 4'd10, 8'd100, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 async clear product", product_o, 0);
    chk("R1 async clear iter", iter_o, 0);
    chk("R1 async clear done", done_o, 0);
    repeat (2) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    run_mult(4'd2, 4'd7, 8'd14, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule